// File: doc/BRIEF.md
# Inter-Processor Message Mailbox

This peripheral lets several processors exchange 32-bit words through a set of small hardware queues. Every queue has a message port: a bus write appends a word, and a bus read removes the oldest word. Beside each queue sit a full flag and a fill-level register. Each processor ("user") owns a pair of registers. One is an event status register with write-1-to-clear bits. The other is an event enable register. Together they drive that user's interrupt line. Every queue reports two events: a word arrived, and the queue left the full state.

Access goes through a simple register port: a write strobe, a read strobe, a byte address and 32-bit data. Read data is registered, so it appears one cycle after the read strobe. A self-clearing soft-reset request empties all queues and clears all status and enable bits over a fixed number of cycles. A done flag reports when that work has finished. A revision register returns a fixed version code.

Top module: `mbx_top`

## Requirements
- R1: After hardware reset every queue is empty, every status and enable register reads 0, every interrupt line is low, the reset-done flag (bit 0 of the system status register at 0x014) reads 1, and the revision register at 0x000 reads major number in bits 7:4 and minor number in bits 3:0 (0x10 by default).
- R2: A write to the message register of queue m (0x040+4m) appends the write data. A read of it returns the oldest stored word on bus_rdata in the cycle after the read strobe and removes it, so words come out in arrival order.
- R3: The fill-level register of queue m (0x0C0+4m) reads the number of stored words (0 when empty). The full register of queue m (0x080+4m) reads 1 when the queue holds its full depth and 0 otherwise.
- R4: A write to a full queue is discarded and leaves its contents unchanged. A read of an empty queue returns 0 and leaves the queue unchanged.
- R5: Every accepted write to queue m sets bit 2m of the status register of every user.
- R6: A read that takes queue m from full to not full sets bit 2m+1 of the status register of every user. A read from a queue that was not full does not set it.
- R7: The status register of user u (0x100+8u) clears each bit written as 1 and keeps each bit written as 0. The enable register of user u (0x104+8u) is read/write.
- R8: irq_o[u] is high exactly when some bit is set both in the status and in the enable register of user u, starting right after the clock edge that changed either register.
- R9: Writing 1 to bit 1 of the system configuration register (0x010) starts a soft reset lasting RST_CYCLES cycles. While it runs, that bit reads 1 and the reset-done flag reads 0. It empties every queue and clears every status and enable register. Afterwards the configuration bit reads 0 and the reset-done flag reads 1.
- R10: A read of any address that maps to no register (including misaligned addresses and indices past the last queue or user) returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| irq_o | output | NUM_USERS | One interrupt line per user |

## Verification
Every register update happens at the rising edge that samples the strobe. Interrupt lines follow from registered state without further delay, and read data is registered, so a read's result is due one cycle after its strobe. The bench drives each access at a falling edge and samples the result at the next falling edge. Every read result and every interrupt level is therefore checked in exactly the cycle it is due, including the back-to-back accesses across the soft-reset window. The soft reset is probed on consecutive cycles to catch a window that is one cycle too long or too short.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    // Register offsets; software decodes these, so they are fixed.
    localparam int OFS_REV = 'h000;
    localparam int OFS_CFG = 'h010;
    localparam int OFS_STS = 'h014;
    localparam int OFS_MSG = 'h040;
    localparam int OFS_FST = 'h080;
    localparam int OFS_CNT = 'h0C0;
    localparam int OFS_USR = 'h100;
    localparam int MSG_STRIDE = 4;
    localparam int USR_STRIDE = 8;

    localparam int CFG_SRST_BIT = 1;
    localparam int STS_DONE_BIT = 0;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_REV, SEL_CFG, SEL_STS,
        SEL_MSG, SEL_FST, SEL_CNT, SEL_IST, SEL_IEN
    } reg_sel_e;
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         push,
    input  logic                         pop,
    input  logic [WIDTH-1:0]             wdata,
    output logic [WIDTH-1:0]             head,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         push_acc,
    output logic                         pop_acc
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [PW-1:0]               wp;
        logic [PW-1:0]               rp;
        logic [CW-1:0]               cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     empty;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d     = st_q;
        full     = (st_q.cnt == CW'(DEPTH));
        empty    = (st_q.cnt == '0);
        push_acc = push & ~full;
        pop_acc  = pop & ~empty;
        if (clr) begin
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.cnt = '0;
        end else begin
            if (push_acc) begin
                st_d.mem[st_q.wp] = wdata;
                st_d.wp           = bump(st_q.wp);
            end
            if (pop_acc) begin
                st_d.rp = bump(st_q.rp);
            end
            st_d.cnt = st_q.cnt + CW'(push_acc) - CW'(pop_acc);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head  = empty ? '0 : st_q.mem[st_q.rp];
    assign count = st_q.cnt;

    // R4
    drop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !clr) |=> (count == $past(count) && head == $past(head)));
    // R4
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && count == '0 && !clr) |=> (count == '0));
    // R3
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
endmodule

// File: rtl/mbx_irq_unit.sv
module mbx_irq_unit #(
    parameter int EV_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic [EV_W-1:0] ev_set,
    input  logic            st_w1c,
    input  logic            en_we,
    input  logic [EV_W-1:0] wdata,
    output logic [EV_W-1:0] status,
    output logic [EV_W-1:0] enable,
    output logic            irq
);
    typedef struct packed {
        logic [EV_W-1:0] status;
        logic [EV_W-1:0] enable;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else begin
            // A new event wins over a simultaneous clear of the same bit.
            st_d.status = (st_q.status & ~(st_w1c ? wdata : '0)) | ev_set;
            if (en_we) st_d.enable = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = st_q.status;
    assign enable = st_q.enable;
    assign irq    = |(st_q.status & st_q.enable);

    // R7
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_w1c && !clr && ev_set == '0) |=> ((status & $past(wdata)) == '0));
    // R5
    event_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|ev_set) && !clr) |=> ((status & $past(ev_set)) == $past(ev_set)));
    // R9
    clr_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (status == '0 && enable == '0 && !irq));
endmodule

// File: rtl/mbx_top.sv
module mbx_top
    import mbx_pkg::*;
#(
    parameter int NUM_MBOX   = 4,
    parameter int FIFO_DEPTH = 4,
    parameter int NUM_USERS  = 4,
    parameter int RST_CYCLES = 3,
    parameter int REV_MAJOR  = 1,
    parameter int REV_MINOR  = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [11:0]          bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic [NUM_USERS-1:0] irq_o
);
    localparam int EV_W = 2 * NUM_MBOX;
    localparam int CW   = $clog2(FIFO_DEPTH + 1);
    localparam int RCW  = $clog2(RST_CYCLES + 1);

    typedef struct packed {
        logic [RCW-1:0]    rst_cnt;
        logic [DATA_W-1:0] rdata;
    } top_st_t;

    top_st_t st_d, st_q;

    reg_sel_e sel;
    int       idx;
    logic     busy;

    logic [NUM_MBOX-1:0]               push, pop, push_acc, pop_acc, full;
    logic [NUM_MBOX-1:0][DATA_W-1:0]   head;
    logic [NUM_MBOX-1:0][CW-1:0]       count;
    logic [EV_W-1:0]                   ev;
    logic [NUM_USERS-1:0]              st_w1c, en_we;
    logic [NUM_USERS-1:0][EV_W-1:0]    status, enable;

    // Address decode
    always_comb begin
        int a;
        a   = int'(bus_addr);
        sel = SEL_NONE;
        idx = 0;
        if (a[1:0] == 2'b00) begin
            if (a == OFS_REV)      sel = SEL_REV;
            else if (a == OFS_CFG) sel = SEL_CFG;
            else if (a == OFS_STS) sel = SEL_STS;
            else if (a >= OFS_MSG && a < OFS_MSG + MSG_STRIDE * NUM_MBOX) begin
                sel = SEL_MSG; idx = (a - OFS_MSG) / MSG_STRIDE;
            end else if (a >= OFS_FST && a < OFS_FST + MSG_STRIDE * NUM_MBOX) begin
                sel = SEL_FST; idx = (a - OFS_FST) / MSG_STRIDE;
            end else if (a >= OFS_CNT && a < OFS_CNT + MSG_STRIDE * NUM_MBOX) begin
                sel = SEL_CNT; idx = (a - OFS_CNT) / MSG_STRIDE;
            end else if (a >= OFS_USR && a < OFS_USR + USR_STRIDE * NUM_USERS) begin
                idx = (a - OFS_USR) / USR_STRIDE;
                sel = a[2] ? SEL_IEN : SEL_IST;
            end
        end
    end

    assign busy = (st_q.rst_cnt != '0);

    // Access strobes
    always_comb begin
        for (int m = 0; m < NUM_MBOX; m++) begin
            push[m] = bus_wr && !busy && sel == SEL_MSG && idx == m;
            pop[m]  = bus_rd && !busy && sel == SEL_MSG && idx == m;
        end
        for (int u = 0; u < NUM_USERS; u++) begin
            st_w1c[u] = bus_wr && !busy && sel == SEL_IST && idx == u;
            en_we[u]  = bus_wr && !busy && sel == SEL_IEN && idx == u;
        end
    end

    for (genvar m = 0; m < NUM_MBOX; m++) begin : g_mbox
        mbx_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) fifo_i (
            .clk(clk), .rst_n(rst_n), .clr(busy),
            .push(push[m]), .pop(pop[m]), .wdata(bus_wdata),
            .head(head[m]), .count(count[m]), .full(full[m]),
            .push_acc(push_acc[m]), .pop_acc(pop_acc[m])
        );
        assign ev[2*m]   = push_acc[m];
        assign ev[2*m+1] = pop_acc[m] & full[m];
    end

    for (genvar u = 0; u < NUM_USERS; u++) begin : g_user
        mbx_irq_unit #(.EV_W(EV_W)) irq_i (
            .clk(clk), .rst_n(rst_n), .clr(busy), .ev_set(ev),
            .st_w1c(st_w1c[u]), .en_we(en_we[u]), .wdata(bus_wdata[EV_W-1:0]),
            .status(status[u]), .enable(enable[u]), .irq(irq_o[u])
        );
    end

    // Next state: soft-reset counter and registered read data
    always_comb begin
        st_d = st_q;
        if (busy) begin
            st_d.rst_cnt = st_q.rst_cnt - 1'b1;
        end else if (bus_wr && sel == SEL_CFG && bus_wdata[CFG_SRST_BIT]) begin
            st_d.rst_cnt = RCW'(RST_CYCLES);
        end
        if (bus_rd) begin
            st_d.rdata = '0;
            unique case (sel)
                SEL_REV: st_d.rdata = DATA_W'(((REV_MAJOR % 16) * 16) + (REV_MINOR % 16));
                SEL_CFG: st_d.rdata[CFG_SRST_BIT] = busy;
                SEL_STS: st_d.rdata[STS_DONE_BIT] = !busy;
                SEL_MSG: for (int m = 0; m < NUM_MBOX; m++)
                             if (idx == m) st_d.rdata = head[m];
                SEL_FST: for (int m = 0; m < NUM_MBOX; m++)
                             if (idx == m) st_d.rdata = DATA_W'(full[m]);
                SEL_CNT: for (int m = 0; m < NUM_MBOX; m++)
                             if (idx == m) st_d.rdata = DATA_W'(count[m]);
                SEL_IST: for (int u = 0; u < NUM_USERS; u++)
                             if (idx == u) st_d.rdata = DATA_W'(status[u]);
                SEL_IEN: for (int u = 0; u < NUM_USERS; u++)
                             if (idx == u) st_d.rdata = DATA_W'(enable[u]);
                default: st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;

    // R10
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && sel == SEL_NONE) |=> (bus_rdata == '0));
    // R9
    srst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !busy && sel == SEL_CFG && bus_wdata[CFG_SRST_BIT]) |=> busy);
    // R9
    srst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (full == '0 && irq_o == '0));
endmodule

// File: tb/mbx_top_tb_top.sv
module mbx_top_tb_top;
    localparam int NM = 4;
    localparam int NU = 4;
    localparam int DEP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NU-1:0] irq_o;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    always #4ns clk = ~clk;

    mbx_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o)
    );

    function automatic int a_msg(int m); return 'h040 + 4 * m; endfunction
    function automatic int a_fst(int m); return 'h080 + 4 * m; endfunction
    function automatic int a_cnt(int m); return 'h0C0 + 4 * m; endfunction
    function automatic int a_ist(int u); return 'h100 + 8 * u; endfunction
    function automatic int a_ien(int u); return 'h104 + 8 * u; endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Each access is set up at a falling edge, sampled at the next rising edge,
    // and the task returns at the following falling edge.
    task automatic wr(input int a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = 12'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = 12'(a);
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state
        rd('h000, v); chk("R1 revision", v, 32'h10);
        rd('h014, v); chk("R1 reset done", v, 32'h1);
        chk("R1 irq idle", 32'(irq_o), 32'h0);
        for (int m = 0; m < NM; m++) begin
            rd(a_cnt(m), v); chk("R1 queue empty", v, 0);
        end
        for (int u = 0; u < NU; u++) begin
            rd(a_ist(u), v); chk("R1 status zero", v, 0);
            rd(a_ien(u), v); chk("R1 enable zero", v, 0);
        end

        // Per-queue fill, overflow, drain and underflow
        for (int m = 0; m < NM; m++) begin
            for (int k = 0; k <= DEP; k++) begin
                wr(a_msg(m), 32'hA000_0000 | (m << 8) | k);
                rd(a_cnt(m), v); chk("R3 level", v, (k < DEP) ? k + 1 : DEP);
                rd(a_fst(m), v); chk("R3 R4 full flag", v, (k >= DEP - 1) ? 1 : 0);
            end
            for (int u = 0; u < NU; u++) begin
                rd(a_ist(u), v); chk("R5 new-message bit", v, 32'(1) << (2 * m));
            end
            wr(a_ist(0), 32'h0);
            rd(a_ist(0), v); chk("R7 write zero keeps", v, 32'(1) << (2 * m));
            for (int u = 0; u < NU; u++) begin
                wr(a_ist(u), 32'hFF);
                rd(a_ist(u), v); chk("R7 write one clears", v, 0);
            end
            for (int k = 0; k < DEP; k++) begin
                rd(a_msg(m), v); chk("R2 R4 order", v, 32'hA000_0000 | (m << 8) | k);
                if (k == 0) begin
                    for (int u = 0; u < NU; u++) begin
                        rd(a_ist(u), v); chk("R6 not-full bit", v, 32'(1) << (2 * m + 1));
                        wr(a_ist(u), 32'hFF);
                    end
                end
            end
            rd(a_ist(0), v); chk("R6 no event from non-full", v, 0);
            rd(a_msg(m), v); chk("R4 empty read", v, 0);
            rd(a_cnt(m), v); chk("R4 empty unchanged", v, 0);
            chk("R8 no enable no irq", 32'(irq_o), 0);
        end

        // Status 0x0D: queue 0 push (bit0), queue 1 pushes (bit2) and full->not-full (bit3)
        wr(a_msg(0), 32'h1);
        for (int k = 0; k < DEP; k++) wr(a_msg(1), 32'h2);
        rd(a_msg(1), v);
        for (int u = 0; u < NU; u++) begin
            for (int e = 0; e < 256; e++) begin
                wr(a_ien(u), 32'(e));
                chk("R8 irq mask", 32'(irq_o), ((e & 'h0D) != 0) ? (32'(1) << u) : 0);
            end
            wr(a_ien(u), 32'hA5);
            rd(a_ien(u), v); chk("R7 enable readback", v, 32'hA5);
            if (u == NU - 1) break;
            wr(a_ien(u), 32'h0);
        end

        // Soft reset window
        wr('h010, 32'h2);
        rd('h010, v); chk("R9 busy bit", v, 32'h2);
        rd('h014, v); chk("R9 done low", v, 32'h0);
        rd('h014, v); chk("R9 done low last", v, 32'h0);
        rd('h014, v); chk("R9 done back", v, 32'h1);
        rd('h010, v); chk("R9 busy cleared", v, 32'h0);
        chk("R9 irq cleared", 32'(irq_o), 0);
        for (int m = 0; m < 2; m++) begin
            rd(a_cnt(m), v); chk("R9 queue emptied", v, 0);
        end
        rd(a_ist(0), v); chk("R9 status cleared", v, 0);
        rd(a_ien(NU - 1), v); chk("R9 enable cleared", v, 0);

        // Unmapped addresses
        rd('h004, v); chk("R10 hole", v, 0);
        rd(a_msg(NM), v); chk("R10 past last queue", v, 0);
        rd(a_ist(NU), v); chk("R10 past last user", v, 0);
        rd('h042, v); chk("R10 misaligned", v, 0);
        rd('h000, v); chk("R1 revision kept", v, 32'h10);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule